// File: doc/BRIEF.md
# Two-Thread Interleaved Fetch

This block fronts a pipeline shared by two hardware threads that take turns cycle by cycle. It holds one program counter per thread and a parity bit. On every clock it fetches one instruction, from thread 0 on even cycles and from thread 1 on odd cycles. The fetched word comes from a synchronous instruction memory model and leaves the block tagged with the number of its thread. The tag picks that thread's register bank when the decode stage reads operands. It then rides a chain of stage latches to writeback, where it picks the bank that receives the result.

Because the threads strictly alternate, two neighbouring stages never hold instructions of the same thread. Decode and writeback are three latches apart, which is an odd distance, so they always belong to different threads. The block therefore needs no forwarding paths and no hazard interlock. A taken branch resolved downstream comes back as a redirect tagged with a thread, and only that thread's program counter is rewritten.

Top module: `interleaved_fetch`

## Requirements
- R1: While `rst_n` is low, `dec_vld` and `wb_vld` read 0 and every register of both banks is cleared to zero. The first fetch after reset is thread 0 at `START0`, and thread 1 begins at `START1`.
- R2: From the first valid decode cycle on, `dec_tid` alternates every cycle, starting with 0.
- R3: With no redirect, each fetch of a thread uses the address of its previous fetch plus 4.
- R4: `dec_instr` equals the memory model word for `dec_pc`: with w = `dec_pc` >> 2 (32-bit), the word is (w * 0x9E3779B9) XOR 0x0F0F0F0F, truncated to 32 bits.
- R5: A redirect (`redir_vld` high at a rising edge) carries a thread number and a target. If it arrives at an edge where the other thread fetches, the named thread's next fetch uses the target, and later fetches step from it. The other thread's address sequence is not disturbed.
- R6: If a redirect arrives at the same edge where the named thread fetches, that fetch still uses the old address. The thread's following fetch uses the target.
- R7: `wb_vld`, `wb_tid` and `wb_rd` equal the decode-stage values three cycles earlier: `dec_vld`, `dec_tid` and `dec_instr[15:11]`.
- R8: A writeback changes only the bank selected by `wb_tid`. The same register index in the other thread's bank keeps its value.
- R9: `dec_opa` is the register at index `dec_instr[25:21]`, and `dec_opb` the register at index `dec_instr[20:16]`, both read from the bank of `dec_tid`. The read sees every writeback committed at earlier edges.
- R10: At a rising edge, `wb_data` is written to register `wb_rd` of bank `wb_tid` only when `wb_en` and `wb_vld` are both high. Otherwise no register changes.
- R11: Whenever `dec_vld` and `wb_vld` are both high, `dec_tid` differs from `wb_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| redir_vld | input | 1 | Taken-branch redirect present |
| redir_tid | input | 1 | Thread whose program counter is rewritten |
| redir_pc | input | AW | Redirect target byte address |
| dec_vld | output | 1 | Decode stage holds a fetched instruction |
| dec_tid | output | 1 | Thread of the decode-stage instruction |
| dec_pc | output | AW | Fetch address of the decode-stage instruction |
| dec_instr | output | 32 | Fetched instruction word |
| dec_opa | output | XLEN | First source operand from the owning bank |
| dec_opb | output | XLEN | Second source operand from the owning bank |
| wb_en | input | 1 | Execute side asks to write the writeback result |
| wb_data | input | XLEN | Result to write |
| wb_vld | output | 1 | Writeback stage holds an instruction |
| wb_tid | output | 1 | Thread tag carried to writeback |
| wb_rd | output | 5 | Destination register index carried to writeback |

## Verification
A parity bit that slips shows up one cycle later as two equal `dec_tid` values in a row. The matching `dec_pc` then belongs to the wrong sequence. A program counter that is stepped, redirected or reset wrongly shows up the next time its own thread reaches decode, two cycles after the edge that corrupted it. Every fetch is therefore compared against an address sequence predicted per thread. A tag latch that drops or swaps its contents appears three cycles after decode on `wb_tid` or `wb_rd`. A write steered to the wrong bank, or made while `wb_en` is low, stays hidden until the affected thread later reads that register as an operand. For that reason, operand reads are compared every cycle against a model of both banks that lives only in the bench.

// File: rtl/tf_pkg.sv
// Package: shared types, field positions and the instruction memory
// content function of the two-thread interleaved fetch block.
// Assumes exactly two threads selected by a one-bit tag.
package tf_pkg;

    localparam int NUM_THREADS = 2;
    localparam int TID_W       = 1;
    localparam int REG_IDX_W   = 5;
    localparam int INSTR_W     = 32;

    // Operand and destination field positions decoded from the word
    localparam int SRC_A_LSB   = 21;
    localparam int SRC_B_LSB   = 16;
    localparam int DST_LSB     = 11;

    localparam logic [31:0] IMEM_MULT = 32'h9E37_79B9;
    localparam logic [31:0] IMEM_MASK = 32'h0F0F_0F0F;

    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        logic                 vld;
        tid_t                 tid;
        logic [REG_IDX_W-1:0] dst;
    } stage_tag_t;

    // Content of the memory model: a scrambled function of the word address
    function automatic logic [31:0] imem_word(input logic [31:0] byte_addr);
        logic [31:0] widx;
        widx = {2'b00, byte_addr[31:2]};
        return (widx * IMEM_MULT) ^ IMEM_MASK;
    endfunction

endpackage

// File: rtl/tf_pc_sequencer.sv
// Module: tf_pc_sequencer
// Holds one program counter per thread plus the cycle parity bit.
// The thread named by the parity is fetched at the coming edge, and its
// counter steps by STEP bytes there. A redirect overrides that step and
// touches only the named thread. Assumes the reset is synchronous and
// active low, and that the parity starts at thread 0.
module tf_pc_sequencer
    import tf_pkg::*;
#(
    parameter int             AW     = 32,
    parameter logic [AW-1:0]  START0 = '0,
    parameter logic [AW-1:0]  START1 = '0,
    parameter int             STEP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redir_vld,
    input  tid_t          redir_tid,
    input  logic [AW-1:0] redir_pc,
    output tid_t          slot_tid,
    output logic [AW-1:0] slot_pc
);

    localparam logic [AW-1:0] STEP_INC = AW'(STEP);

    tid_t          slot_q;
    logic [AW-1:0] pc_all [NUM_THREADS];

    // Parity bit: flips every cycle, thread 0 owns the first slot
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= ~slot_q;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        localparam logic [AW-1:0] START = (t == 0) ? START0 : START1;
        logic [AW-1:0] pc_q;
        logic          own_redir;
        logic          own_slot;

        assign own_redir = redir_vld && (redir_tid == tid_t'(t));
        assign own_slot  = (slot_q == tid_t'(t));

        // Per-thread counter: redirect wins over the sequential step
        always_ff @(posedge clk) begin
            if (!rst_n)         pc_q <= START;
            else if (own_redir) pc_q <= redir_pc;
            else if (own_slot)  pc_q <= pc_q + STEP_INC;
        end

        assign pc_all[t] = pc_q;
    end

    assign slot_tid = slot_q;
    assign slot_pc  = pc_all[slot_q];

endmodule

// File: rtl/tf_imem.sv
// Module: tf_imem
// Synchronous instruction memory model. The address is sampled at a rising
// edge and the word appears on rd_data after that edge. The content is
// computed from the address, so the model holds no storage array.
// Assumes a read is issued every cycle.
module tf_imem
    import tf_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [IW-1:0] rd_data
);

    logic [31:0] addr32;
    assign addr32 = 32'(rd_addr);

    // Registered read: one cycle from address to word
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= IW'(imem_word(addr32));
    end

endmodule

// File: rtl/tf_tag_pipe.sv
// Module: tf_tag_pipe
// Carries the thread tag, valid bit and destination index from decode to
// writeback through DEPTH stage latches. Assumes DEPTH is odd, so the
// stage at the far end always belongs to the thread not in decode.
module tf_tag_pipe
    import tf_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  stage_tag_t in_tag,
    output stage_tag_t out_tag
);

    stage_tag_t chain [DEPTH+1];

    assign chain[0] = in_tag;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        stage_tag_t tag_q;

        // Stage latch: moves the tag one stage on each cycle
        always_ff @(posedge clk) begin
            if (!rst_n) tag_q <= '0;
            else        tag_q <= chain[s];
        end

        assign chain[s+1] = tag_q;
    end

    assign out_tag = chain[DEPTH];

endmodule

// File: rtl/tf_reg_banks.sv
// Module: tf_reg_banks
// One register bank per thread. Two combinational read ports are steered
// by the decode-stage tag, and one write port by the writeback tag.
// Assumes the writer and the reader are never the same thread in one
// cycle, so no write-to-read bypass is built.
module tf_reg_banks
    import tf_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tid_t             rd_tid,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]  rd_data_a,
    output logic [XLEN-1:0]  rd_data_b,
    input  logic             wr_en,
    input  tid_t             wr_tid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);

    logic [XLEN-1:0] port_a [NUM_THREADS];
    logic [XLEN-1:0] port_b [NUM_THREADS];

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bank
        logic [XLEN-1:0] regs [NREG];
        logic            sel_wr;

        assign sel_wr = wr_en && (wr_tid == tid_t'(t));

        // Bank storage: cleared by reset, written only when tag matches
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < NREG; k++) regs[k] <= '0;
            end else if (sel_wr) begin
                regs[wr_idx] <= wr_data;
            end
        end

        assign port_a[t] = regs[rd_idx_a];
        assign port_b[t] = regs[rd_idx_b];
    end

    assign rd_data_a = port_a[rd_tid];
    assign rd_data_b = port_b[rd_tid];

endmodule

// File: rtl/interleaved_fetch.sv
// Module: interleaved_fetch (top)
// Fetch and thread steering for a pipeline shared by two threads that
// alternate every cycle. The top wires together the sequencer, the memory
// model, the register banks and the tag latches. It also registers the
// decode-stage address and tag next to the memory output. Assumes WB_DEPTH
// is odd, so decode and writeback never belong to the same thread.
module interleaved_fetch
    import tf_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            XLEN     = 32,
    parameter int            NREG     = 32,
    parameter logic [AW-1:0] START0   = AW'(32'h0000_0100),
    parameter logic [AW-1:0] START1   = AW'(32'h0000_0400),
    parameter int            WB_DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redir_vld,
    input  logic                 redir_tid,
    input  logic [AW-1:0]        redir_pc,
    output logic                 dec_vld,
    output logic                 dec_tid,
    output logic [AW-1:0]        dec_pc,
    output logic [INSTR_W-1:0]   dec_instr,
    output logic [XLEN-1:0]      dec_opa,
    output logic [XLEN-1:0]      dec_opb,
    input  logic                 wb_en,
    input  logic [XLEN-1:0]      wb_data,
    output logic                 wb_vld,
    output logic                 wb_tid,
    output logic [REG_IDX_W-1:0] wb_rd
);

    localparam int PC_STEP = INSTR_W / 8;

    tid_t          slot_tid;
    logic [AW-1:0] slot_pc;
    stage_tag_t    dec_tag;
    stage_tag_t    wb_tag;

    tf_pc_sequencer #(
        .AW     (AW),
        .START0 (START0),
        .START1 (START1),
        .STEP   (PC_STEP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .redir_vld (redir_vld),
        .redir_tid (redir_tid),
        .redir_pc  (redir_pc),
        .slot_tid  (slot_tid),
        .slot_pc   (slot_pc)
    );

    tf_imem #(
        .AW (AW),
        .IW (INSTR_W)
    ) u_imem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (slot_pc),
        .rd_data (dec_instr)
    );

    // Decode-stage latch: address and tag aligned with the memory word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            dec_tid <= 1'b0;
            dec_pc  <= '0;
        end else begin
            dec_vld <= 1'b1;
            dec_tid <= slot_tid;
            dec_pc  <= slot_pc;
        end
    end

    assign dec_tag.vld = dec_vld;
    assign dec_tag.tid = dec_tid;
    assign dec_tag.dst = dec_instr[DST_LSB +: REG_IDX_W];

    tf_tag_pipe #(
        .DEPTH (WB_DEPTH)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tag  (dec_tag),
        .out_tag (wb_tag)
    );

    assign wb_vld = wb_tag.vld;
    assign wb_tid = wb_tag.tid;
    assign wb_rd  = wb_tag.dst;

    tf_reg_banks #(
        .XLEN  (XLEN),
        .NREG  (NREG),
        .IDX_W (REG_IDX_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_tid    (dec_tid),
        .rd_idx_a  (dec_instr[SRC_A_LSB +: REG_IDX_W]),
        .rd_idx_b  (dec_instr[SRC_B_LSB +: REG_IDX_W]),
        .rd_data_a (dec_opa),
        .rd_data_b (dec_opb),
        .wr_en     (wb_en & wb_vld),
        .wr_tid    (wb_tid),
        .wr_idx    (wb_rd),
        .wr_data   (wb_data)
    );

endmodule

// File: rtl/interleaved_fetch_chk.sv
// Module: interleaved_fetch_chk
// Property checker for interleaved_fetch, attached by bind. It watches only
// the ports of the top. Assumes rst_n is low at time zero.
module interleaved_fetch_chk
    import tf_pkg::*;
#(
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 redir_vld,
    input logic                 redir_tid,
    input logic                 dec_vld,
    input logic                 dec_tid,
    input logic [AW-1:0]        dec_pc,
    input logic [INSTR_W-1:0]   dec_instr,
    input logic                 wb_vld,
    input logic                 wb_tid,
    input logic [REG_IDX_W-1:0] wb_rd
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!dec_vld && !wb_vld)); // R1

    AST_THREAD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(dec_vld)) |-> (dec_tid != $past(dec_tid))); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(dec_vld, 2)
         && !($past(redir_vld, 2) && ($past(redir_tid, 2) == dec_tid))
         && !($past(redir_vld, 3) && ($past(redir_tid, 3) == dec_tid)))
        |-> (dec_pc == $past(dec_pc, 2) + AW'(4))); // R3

    AST_IMEM_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (dec_instr == imem_word(32'(dec_pc)))); // R4

    AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> ((wb_tid == $past(dec_tid, 3))
                    && (wb_rd == $past(dec_instr[DST_LSB +: REG_IDX_W], 3)))); // R7

    AST_THREADS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && wb_vld) |-> (dec_tid != wb_tid)); // R11

endmodule

bind interleaved_fetch interleaved_fetch_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .redir_vld (redir_vld),
    .redir_tid (redir_tid),
    .dec_vld   (dec_vld),
    .dec_tid   (dec_tid),
    .dec_pc    (dec_pc),
    .dec_instr (dec_instr),
    .wb_vld    (wb_vld),
    .wb_tid    (wb_tid),
    .wb_rd     (wb_rd)
);

// File: tb/test_interleaved_fetch.sv
// Scoreboard bench for interleaved_fetch. A driver step predicts each
// fetch and pushes it into a queue; a monitor step pops and compares at
// the following falling edge. Register banks are modelled in the bench.
module test_interleaved_fetch;

    localparam logic [31:0] S0 = 32'h0000_0100;
    localparam logic [31:0] S1 = 32'h0000_0400;
    localparam int NCYC = 160;

    typedef struct { logic tid; logic [31:0] pc; int lbl; } fexp_t;
    typedef struct { logic vld; logic tid; logic [4:0] rd; } texp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_vld = 1'b0;
    logic        redir_tid = 1'b0;
    logic [31:0] redir_pc = '0;
    logic        wb_en = 1'b0;
    logic [31:0] wb_data = '0;
    logic        dec_vld, dec_tid, wb_vld, wb_tid;
    logic [31:0] dec_pc, dec_instr, dec_opa, dec_opb;
    logic [4:0]  wb_rd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    fexp_t       fq[$];
    texp_t       tq[$];
    logic [31:0] mb [2][32];
    logic [31:0] mpc [2];
    int          lbl [2];
    logic        mpar;

    always #5 clk = ~clk;

    interleaved_fetch #(.START0(S0), .START1(S1)) i_interleaved_fetch (
        .clk(clk), .rst_n(rst_n),
        .redir_vld(redir_vld), .redir_tid(redir_tid), .redir_pc(redir_pc),
        .dec_vld(dec_vld), .dec_tid(dec_tid), .dec_pc(dec_pc), .dec_instr(dec_instr),
        .dec_opa(dec_opa), .dec_opb(dec_opb),
        .wb_en(wb_en), .wb_data(wb_data),
        .wb_vld(wb_vld), .wb_tid(wb_tid), .wb_rd(wb_rd)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {2'b00, a[31:2]};
        return (w * 32'h9E37_79B9) ^ 32'h0F0F_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string lbl_name(input int l);
        if (l == 5) return "R5";
        if (l == 6) return "R6";
        if (l == 1) return "R1";
        return "R3";
    endfunction

    // Monitor: pops predictions and compares them with the ports
    task automatic monitor_step();
        fexp_t e;
        texp_t t;
        logic [31:0] ea, eb;
        if (fq.size() > 0) begin
            e = fq.pop_front();
            chk(dec_vld === 1'b1, "R1", "dec_vld", 32'(dec_vld), 32'd1);
            chk(dec_tid === e.tid, "R2", "dec_tid", 32'(dec_tid), 32'(e.tid));
            chk(dec_pc === e.pc, lbl_name(e.lbl), "dec_pc", dec_pc, e.pc);
            chk(dec_instr === mem_word(dec_pc), "R4", "dec_instr", dec_instr, mem_word(dec_pc));
        end else begin
            chk(dec_vld === 1'b0, "R1", "dec_vld before first fetch", 32'(dec_vld), 32'd0);
        end
        if (dec_vld === 1'b1) begin
            ea = mb[dec_tid][dec_instr[25:21]];
            eb = mb[dec_tid][dec_instr[20:16]];
            chk(dec_opa === ea, "R8/R9/R10", "dec_opa", dec_opa, ea);
            chk(dec_opb === eb, "R8/R9/R10", "dec_opb", dec_opb, eb);
        end
        if (tq.size() == 3) begin
            t = tq.pop_front();
            chk(wb_vld === t.vld, "R7", "wb_vld", 32'(wb_vld), 32'(t.vld));
            if (t.vld) begin
                chk(wb_tid === t.tid, "R7", "wb_tid", 32'(wb_tid), 32'(t.tid));
                chk(wb_rd === t.rd, "R7", "wb_rd", 32'(wb_rd), 32'(t.rd));
            end
        end
        if (dec_vld === 1'b1 && wb_vld === 1'b1)
            chk(dec_tid !== wb_tid, "R11", "dec_tid vs wb_tid", 32'(dec_tid), 32'(~wb_tid));
        tq.push_back('{vld: dec_vld, tid: dec_tid, rd: dec_instr[15:11]});
    endtask

    // Driver: predicts the coming fetch, then drives redirect and writeback
    task automatic driver_step(input int c);
        fexp_t e;
        bit    rv;
        logic  rt;
        logic [31:0] rp;
        e.tid = mpar; e.pc = mpc[mpar]; e.lbl = lbl[mpar];
        fq.push_back(e);
        lbl[mpar] = 3;
        mpc[mpar] = mpc[mpar] + 32'd4;
        rv = 1'b1; rt = 1'b0; rp = '0;
        case (c)
            8:  begin rt = 1'b1; rp = 32'h0000_0800; end
            9:  begin rt = 1'b1; rp = 32'h0000_0A00; end
            30: begin rt = 1'b0; rp = 32'h0000_1000; end
            45: begin rt = 1'b0; rp = 32'h0000_2000; end
            70: begin rt = 1'b1; rp = 32'hFFFF_FFF8; end
            default: rv = 1'b0;
        endcase
        if (rv) begin
            mpc[rt] = rp;
            lbl[rt] = (rt == mpar) ? 6 : 5;
        end
        mpar = ~mpar;
        redir_vld = rv; redir_tid = rt; redir_pc = rp;
        wb_en = ((c % 5) != 2) && !(c >= 100 && c < 112);
        wb_data = (32'(c) * 32'h0100_0193) ^ 32'hA5A5_0000;
        if (wb_en && wb_vld === 1'b1) mb[wb_tid][wb_rd] = wb_data;
    endtask

    initial begin
        for (int t = 0; t < 2; t++)
            for (int k = 0; k < 32; k++) mb[t][k] = '0;
        mpc[0] = S0; mpc[1] = S1;
        lbl[0] = 1; lbl[1] = 1;
        mpar = 1'b0;
        repeat (3) @(negedge clk);
        chk(dec_vld === 1'b0, "R1", "dec_vld in reset", 32'(dec_vld), 32'd0);
        chk(wb_vld === 1'b0, "R1", "wb_vld in reset", 32'(wb_vld), 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) @(negedge clk);
            monitor_step();
            driver_step(c);
        end
        @(negedge clk);
        monitor_step();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule